// File: doc/BRIEF.md
# Resumable NMI Return Unit

This block recognises and carries out the return from a resumable non-maskable interrupt handler inside a privileged processor core. Each cycle it may receive one 32-bit instruction word with a valid strobe. It also receives the current privilege level, the saved PC and saved status of the NMI context, the machine status word, and a few configuration inputs. These inputs say whether the resumable-NMI feature, compressed instructions, the hypervisor feature and memory protection are present, and how many protection rules are programmed.

When the word is the return instruction, the block runs its guards in a fixed order. If any guard fails, it raises one exception request. If all guards pass, it emits a commit bundle. The bundle holds the resume PC, the restored privilege and virtualization mode, the updated NMI status word (NMI enable set again), the updated machine status word, and a strobe that tells the core to swap hypervisor registers. The core owns the register file, the pipeline and the swap itself. All results appear one clock after the strobe, for one cycle.

Top module: `nmi_return_unit`

## Requirements
- R1: Only the word 0x70200073 is treated as the return instruction. Any other word, or a cycle without the valid strobe, produces neither an exception nor a commit.
- R2: When the resumable-NMI feature is disabled, the return raises an exception with cause code 2 (illegal instruction) and produces no commit.
- R3: When the current privilege is not machine mode (encoding 11), the return raises cause 2 and produces no commit.
- R4: When compressed instructions are disabled and either of bits 1:0 of the saved PC is set, the return raises cause 0 (misaligned instruction address). When compressed instructions are enabled, those bits raise nothing and the PC passes through unchanged.
- R5: When memory protection is present, the rule count is zero and the previous privilege is not machine mode, the return raises cause 2.
- R6: Only the first failing guard is reported. The order is: feature disabled, then privilege, then PC alignment, then protection rules.
- R7: On commit, the resume PC equals the saved PC. The new privilege equals bits 12:11 of the saved NMI status. Privilege is encoded 00 user, 01 supervisor, 11 machine.
- R8: On commit, the virtualization mode equals bit 7 of the saved NMI status, but it is forced to 0 when the previous privilege is machine mode.
- R9: On commit, the new NMI status equals the saved one with bit 3 (NMI enable) set. All other bits are unchanged.
- R10: On commit, bit 17 of the machine status (modify-privilege) is cleared when the previous privilege is below machine mode. Otherwise the machine status passes through unchanged.
- R11: The register-swap strobe is high exactly on commits where the hypervisor feature is enabled and the restored virtualization mode is 1.
- R12: All results are registered. They appear one cycle after the strobe, last one cycle when the strobe is not repeated, and are all low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| cur_priv | input | 2 | Current privilege level |
| cfg_rnmi_en | input | 1 | Resumable-NMI feature enabled |
| cfg_compressed_en | input | 1 | Compressed instructions supported |
| cfg_hyp_en | input | 1 | Hypervisor feature enabled |
| cfg_prot_present | input | 1 | Memory protection implemented |
| prot_rule_count | input | RULE_W | Number of programmed protection rules |
| saved_pc | input | XLEN | Saved PC of the NMI context |
| saved_nstatus | input | XLEN | Saved NMI status word |
| cur_mstatus | input | XLEN | Current machine status word |
| exc_valid | output | 1 | Exception request |
| exc_cause | output | 4 | Exception cause code |
| commit_valid | output | 1 | Commit bundle is valid |
| commit_pc | output | XLEN | Resume PC |
| commit_priv | output | 2 | Restored privilege |
| commit_virt | output | 1 | Restored virtualization mode |
| commit_nstatus | output | XLEN | New NMI status word |
| commit_mstatus | output | XLEN | New machine status word |
| hyp_swap | output | 1 | One-cycle hypervisor register-swap strobe |

## Verification
Assertions check four things on every cycle. An exception and a commit never appear together. A commit always follows a strobe made in machine mode. Every committed NMI status carries the enable bit. A commit to machine mode never sets virtualization, and the swap strobe only comes with a virtualized commit.

Some behaviour can only be shown by the bench's scenarios, which compare results against an independent model. These are:
- the exact encoding match;
- the guard priority when several guards fail at once;
- the alignment relief when compressed instructions are enabled;
- the protection-rule corner with zero rules;
- the conditional clearing of the modify-privilege bit;
- the field values passed through.

// File: rtl/nmi_return_unit.sv
module nmi_return_unit #(
  parameter int XLEN     = 32,
  parameter int RULE_W   = 7,
  parameter int MPRV_POS = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  input  logic [1:0]        cur_priv,
  input  logic              cfg_rnmi_en,
  input  logic              cfg_compressed_en,
  input  logic              cfg_hyp_en,
  input  logic              cfg_prot_present,
  input  logic [RULE_W-1:0] prot_rule_count,
  input  logic [XLEN-1:0]   saved_pc,
  input  logic [XLEN-1:0]   saved_nstatus,
  input  logic [XLEN-1:0]   cur_mstatus,
  output logic              exc_valid,
  output logic [3:0]        exc_cause,
  output logic              commit_valid,
  output logic [XLEN-1:0]   commit_pc,
  output logic [1:0]        commit_priv,
  output logic              commit_virt,
  output logic [XLEN-1:0]   commit_nstatus,
  output logic [XLEN-1:0]   commit_mstatus,
  output logic              hyp_swap
);
  localparam logic [31:0] RET_WORD      = 32'h7020_0073;
  localparam logic [1:0]  PRIV_MACHINE  = 2'b11;
  localparam logic [3:0]  CAUSE_ILLEGAL = 4'd2;
  localparam logic [3:0]  CAUSE_ALIGN   = 4'd0;
  localparam int          EN_POS        = 3;
  localparam int          PV_POS        = 7;
  localparam int          PP_LO         = 11;

  logic       hit;
  logic [1:0] prev_priv;
  logic       prev_is_m;
  logic       bad_feature, bad_priv, bad_align, bad_prot, any_bad;
  logic       next_virt;

  assign hit         = instr_valid && (instr_word == RET_WORD);
  assign prev_priv   = saved_nstatus[PP_LO+1:PP_LO];
  assign prev_is_m   = (prev_priv == PRIV_MACHINE);
  assign bad_feature = !cfg_rnmi_en;
  assign bad_priv    = (cur_priv != PRIV_MACHINE);
  assign bad_align   = !cfg_compressed_en && (saved_pc[1:0] != 2'b00);
  assign bad_prot    = cfg_prot_present && (prot_rule_count == '0) && !prev_is_m;
  assign any_bad     = bad_feature | bad_priv | bad_align | bad_prot;
  assign next_virt   = saved_nstatus[PV_POS] && !prev_is_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid      <= 1'b0;
      exc_cause      <= '0;
      commit_valid   <= 1'b0;
      commit_pc      <= '0;
      commit_priv    <= '0;
      commit_virt    <= 1'b0;
      commit_nstatus <= '0;
      commit_mstatus <= '0;
      hyp_swap       <= 1'b0;
    end else begin
      exc_valid    <= hit && any_bad;
      commit_valid <= hit && !any_bad;
      hyp_swap     <= hit && !any_bad && cfg_hyp_en && next_virt;
      if (hit) begin
        if (bad_feature || bad_priv)  exc_cause <= CAUSE_ILLEGAL;
        else if (bad_align)           exc_cause <= CAUSE_ALIGN;
        else                          exc_cause <= CAUSE_ILLEGAL;
        commit_pc              <= saved_pc;
        commit_priv            <= prev_priv;
        commit_virt            <= next_virt;
        commit_nstatus         <= saved_nstatus;
        commit_nstatus[EN_POS] <= 1'b1;
        commit_mstatus         <= cur_mstatus;
        if (!prev_is_m) commit_mstatus[MPRV_POS] <= 1'b0;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_valid && commit_valid)); // R6
  AST_COMMIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(instr_valid)); // R12
  AST_COMMIT_FROM_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(cur_priv) == PRIV_MACHINE); // R3
  AST_ENABLE_REARMED: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> commit_nstatus[EN_POS]); // R9
  AST_MACHINE_NOT_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_priv == PRIV_MACHINE) |-> !commit_virt); // R8
  AST_SWAP_ON_VIRT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_swap |-> (commit_valid && commit_virt)); // R11
endmodule

// File: tb/sim_nmi_return_unit.sv
`timescale 1ns/1ps
module sim_nmi_return_unit;
  localparam int XLEN = 32;
  localparam int RULE_W = 7;
  localparam logic [31:0] RET = 32'h7020_0073;

  logic clk = 0, rst_n = 0;
  logic instr_valid = 0;
  logic [31:0] instr_word = 0;
  logic [1:0] cur_priv = 0;
  logic cfg_rnmi_en = 0, cfg_compressed_en = 0, cfg_hyp_en = 0, cfg_prot_present = 0;
  logic [RULE_W-1:0] prot_rule_count = 0;
  logic [XLEN-1:0] saved_pc = 0, saved_nstatus = 0, cur_mstatus = 0;
  logic exc_valid, commit_valid, commit_virt, hyp_swap;
  logic [3:0] exc_cause;
  logic [1:0] commit_priv;
  logic [XLEN-1:0] commit_pc, commit_nstatus, commit_mstatus;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nmi_return_unit #(.XLEN(XLEN), .RULE_W(RULE_W), .MPRV_POS(17)) u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .cur_priv(cur_priv), .cfg_rnmi_en(cfg_rnmi_en), .cfg_compressed_en(cfg_compressed_en),
    .cfg_hyp_en(cfg_hyp_en), .cfg_prot_present(cfg_prot_present),
    .prot_rule_count(prot_rule_count), .saved_pc(saved_pc), .saved_nstatus(saved_nstatus),
    .cur_mstatus(cur_mstatus), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .commit_valid(commit_valid), .commit_pc(commit_pc), .commit_priv(commit_priv),
    .commit_virt(commit_virt), .commit_nstatus(commit_nstatus),
    .commit_mstatus(commit_mstatus), .hyp_swap(hyp_swap));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_case(logic [31:0] iw, logic [1:0] pr, logic rn, logic cm, logic hy,
                          logic pp, logic [RULE_W-1:0] cnt, logic [XLEN-1:0] pc,
                          logic [XLEN-1:0] ns, logic [XLEN-1:0] ms, string prio_tag);
    logic is_ret, prev_m, e_feat, e_priv, e_align, e_prot, fail, vt;
    logic [3:0] cause;
    string etag;
    is_ret = (iw == RET);
    prev_m = (ns[12:11] == 2'b11);
    e_feat = !rn; e_priv = (pr != 2'b11);
    e_align = !cm && (pc[1:0] != 0);
    e_prot = pp && (cnt == 0) && !prev_m;
    fail = e_feat || e_priv || e_align || e_prot;
    if (e_feat)       begin cause = 4'd2; etag = "R2"; end
    else if (e_priv)  begin cause = 4'd2; etag = "R3"; end
    else if (e_align) begin cause = 4'd0; etag = "R4"; end
    else if (e_prot)  begin cause = 4'd2; etag = "R5"; end
    else              begin cause = 4'd0; etag = "R4"; end
    vt = ns[7] && !prev_m;
    @(negedge clk);
    instr_valid = 1; instr_word = iw; cur_priv = pr; cfg_rnmi_en = rn;
    cfg_compressed_en = cm; cfg_hyp_en = hy; cfg_prot_present = pp;
    prot_rule_count = cnt; saved_pc = pc; saved_nstatus = ns; cur_mstatus = ms;
    @(negedge clk);
    instr_valid = 0;
    if (!is_ret) begin
      chk("R1 exc", exc_valid, 0);
      chk("R1 commit", commit_valid, 0);
    end else begin
      chk({etag, " exc_valid"}, exc_valid, fail);
      chk({etag, " commit_valid"}, commit_valid, !fail);
      if (fail) chk({etag, " cause"}, exc_cause, cause);
      if (fail && prio_tag != "") chk({prio_tag, " cause"}, exc_cause, cause);
      if (!fail) begin
        chk("R7 pc", commit_pc, pc);
        chk("R7 priv", commit_priv, ns[12:11]);
        chk("R8 virt", commit_virt, vt);
        chk("R9 nstatus", commit_nstatus, ns | 32'h8);
        chk("R10 mstatus", commit_mstatus, prev_m ? ms : (ms & ~32'h2_0000));
      end
      chk("R11 swap", hyp_swap, !fail && hy && vt);
    end
    @(negedge clk);
    chk("R12 drop", {exc_valid, commit_valid, hyp_swap}, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset", {exc_valid, commit_valid, hyp_swap}, 0);
    // directed corners
    run_case(RET, 2'b11, 1, 0, 1, 1, 5, 32'h8000_1000, 32'h0000_0880, 32'h0002_0000, "");    // R8 R11 supervisor virt
    run_case(RET, 2'b11, 1, 0, 1, 1, 5, 32'h8000_1000, 32'h0000_1880, 32'h0002_0000, "");    // R8 machine forces virt 0
    run_case(RET, 2'b11, 1, 0, 0, 0, 0, 32'h8000_2000, 32'h0000_0080, 32'hFFFF_FFFF, "");    // R10 user clears bit 17
    run_case(RET ^ 32'h0010_0000, 2'b11, 1, 1, 1, 0, 1, 32'h4, 32'h1800, 0, "");             // R1 rs2 bit flipped
    run_case(RET, 2'b11, 0, 1, 1, 0, 1, 32'h4, 32'h1800, 0, "");                             // R2
    run_case(RET, 2'b01, 1, 1, 1, 0, 1, 32'h4, 32'h1800, 0, "");                             // R3
    run_case(RET, 2'b11, 1, 0, 0, 0, 1, 32'h6, 32'h1800, 0, "");                             // R4 misaligned
    run_case(RET, 2'b11, 1, 1, 0, 0, 1, 32'h6, 32'h1800, 0, "");                             // R4 compressed relief
    run_case(RET, 2'b11, 1, 1, 0, 1, 0, 32'h8, 32'h0800, 0, "");                             // R5 zero rules
    run_case(RET, 2'b11, 1, 1, 0, 1, 0, 32'h8, 32'h1800, 0, "");                             // R5 machine exempt
    run_case(RET, 2'b00, 0, 0, 0, 1, 0, 32'h3, 32'h0000, 0, "R6");                           // feature first
    run_case(RET, 2'b01, 1, 0, 0, 1, 0, 32'h3, 32'h0000, 0, "R6");                           // privilege before align
    run_case(RET, 2'b11, 1, 0, 0, 1, 0, 32'h1, 32'h0000, 0, "R6");                           // align before prot
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] iw;
      logic [1:0] pr;
      iw = ($urandom % 8 == 0) ? (RET ^ (32'h1 << ($urandom % 32))) : RET;
      pr = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
      run_case(iw, pr, ($urandom % 10) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
               ($urandom % 3 == 0) ? '0 : RULE_W'($urandom), $urandom, $urandom, $urandom, "");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule